// File: doc/BRIEF.md
# Ping-Pong Partial-Sum Accumulator Store

This block stores accumulator vectors produced by a matrix array. Every entry holds `LANES` lanes of 32 bits. Each cycle the array may present one vector of 16-bit partial sums, an absolute entry address, a write mode and an extension mode. The write mode either replaces the entry or adds the vector to what is already stored. Each 16-bit lane is widened to 32 bits first, by sign extension or by zero extension. A new vector is accepted every cycle, including back-to-back vectors aimed at the same entry. A two-stage read-modify-write pipeline with a forwarding register keeps those accumulations exact.

The address space is split into two equal halves. The address MSB selects the half. One half is the fill half and takes vectors from the array. The other half is the drain half and is read by the downstream activation path through a local index. A vector aimed at the drain half is dropped, and a flag is raised for it. The two halves trade roles only through a handshake. The fill side raises a swap request, the drain side raises a done pulse, and the two are exchanged once both have been seen, in either order or in the same cycle.

The default depth is 64 entries, split into two halves of 32.

Top module: `acc_pingpong_store`

## Requirements
- R1: With `in_mode`=0 (load), the addressed entry becomes the widened input vector. Input lane i occupies `in_psum[16i+15:16i]` and stored lane i occupies bits `[32i+31:32i]`.
- R2: With `in_mode`=1 (add), every lane of the addressed entry becomes its previous value plus the widened input lane.
- R3: `in_signed`=1 sign-extends each 16-bit lane to 32 bits and `in_signed`=0 zero-extends it.
- R4: The lane add wraps modulo 2^32 and never saturates.
- R5: One vector is accepted every cycle. Writes to the same entry in consecutive cycles, or two cycles apart, give the same result as if they had been applied one after another.
- R6: A write whose address MSB differs from `fill_half` leaves memory unchanged, and `in_reject` is high in the cycle after it. An accepted write leaves `in_reject` low in the cycle after it.
- R7: `fill_half` toggles in the cycle after a swap request and a drain-done pulse have both been seen, in either order or together. Either one alone leaves it unchanged.
- R8: `rd_en` with `rd_idx` returns the entry `{~fill_half, rd_idx}` on `rd_data`, with `rd_valid` high, one cycle later. `rd_valid` is low otherwise.
- R9: After reset, `fill_half`, `in_reject` and `rd_valid` are 0.
- R10: After a swap, the entries written while a half was the fill half can be read from it as the drain half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Partial-sum vector present |
| in_addr | input | AW | Absolute entry address; the MSB selects the half |
| in_mode | input | 1 | 0 = load, 1 = add |
| in_signed | input | 1 | 1 = sign-extend lanes, 0 = zero-extend |
| in_psum | input | LANES*16 | Partial-sum lanes |
| in_reject | output | 1 | Previous write aimed at the drain half |
| swap_req | input | 1 | Fill side asks for an exchange |
| drain_done | input | 1 | Drain side has finished its half |
| fill_half | output | 1 | Half currently taking writes |
| rd_en | input | 1 | Drain read request |
| rd_idx | input | AW-1 | Entry index inside the drain half |
| rd_valid | output | 1 | `rd_data` holds a read result |
| rd_data | output | LANES*32 | Drain read data |

## Verification
Loads with mixed lane signs, in both extension modes, separate sign extension from zero extension. Running sums built in consecutive cycles and at a distance of two cycles each exercise a different source of the previous value: the forwarding register for the first, settled memory for the second. A signed all-ones or negative lane plus an unsigned increment shows that the add wraps to zero rather than saturating. Swap pulses given request-first, done-first and together, and writes aimed at the drain half followed by a drain read of the targeted entry, show that neither the exchange nor the rejection can occur early.

// File: rtl/acc_pkg.sv
package acc_pkg;
  typedef enum logic {
    WM_LOAD = 1'b0,
    WM_ADD  = 1'b1
  } wmode_e;
endpackage

// File: rtl/acc_lane_alu.sv
module acc_lane_alu
  import acc_pkg::*;
#(
  parameter int PS_W  = 16,
  parameter int ACC_W = 32
) (
  input  logic [PS_W-1:0]  psum,
  input  logic             is_signed,
  input  wmode_e           mode,
  input  logic [ACC_W-1:0] prior,
  output logic [ACC_W-1:0] result
);
  localparam int PAD = ACC_W - PS_W;

  logic [ACC_W-1:0] widened;

  always_comb begin
    widened = {{PAD{is_signed & psum[PS_W-1]}}, psum};
    // modulo 2^ACC_W add, carry out dropped (R4)
    result  = (mode == WM_ADD) ? prior + widened : widened;
  end
endmodule

// File: rtl/acc_bank.sv
module acc_bank #(
  parameter int WIDTH = 128,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re_a,
  input  logic [AW-1:0]    raddr_a,
  output logic [WIDTH-1:0] rdata_a,
  input  logic             re_b,
  input  logic [AW-1:0]    raddr_b,
  output logic [WIDTH-1:0] rdata_b
);
  logic [WIDTH-1:0] mem [DEPTH];

  // one write port, two registered read ports; read-during-write returns old data
  always_ff @(posedge clk) begin
    if (we)   mem[waddr] <= wdata;
    if (re_a) rdata_a    <= mem[raddr_a];
    if (re_b) rdata_b    <= mem[raddr_b];
  end
endmodule

// File: rtl/acc_swap_ctrl.sv
module acc_swap_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic swap_req,
  input  logic drain_done,
  output logic fill_half
);
  logic req_q, done_q;
  logic req_seen, done_seen;

  always_comb begin
    req_seen  = req_q | swap_req;
    done_seen = done_q | drain_done;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_half <= 1'b0;
      req_q     <= 1'b0;
      done_q    <= 1'b0;
    end else if (req_seen && done_seen) begin
      fill_half <= ~fill_half;
      req_q     <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      req_q     <= req_seen;
      done_q    <= done_seen;
    end
  end

  p_swap_needs_done_r7: assert property (@(posedge clk) disable iff (rst)
    (fill_half != $past(fill_half)) |-> $past(drain_done || done_q));

  p_swap_needs_req_r7: assert property (@(posedge clk) disable iff (rst)
    (fill_half != $past(fill_half)) |-> $past(swap_req || req_q));

  p_swap_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (fill_half != $past(fill_half)) |-> (!req_q && !done_q));
endmodule

// File: rtl/acc_pingpong_store.sv
module acc_pingpong_store
  import acc_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int PS_W   = 16,
  parameter int ACC_W  = 32,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int HW    = AW - 1,
  localparam int IN_W  = LANES * PS_W,
  localparam int VEC_W = LANES * ACC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [AW-1:0]    in_addr,
  input  logic             in_mode,
  input  logic             in_signed,
  input  logic [IN_W-1:0]  in_psum,
  output logic             in_reject,
  input  logic             swap_req,
  input  logic             drain_done,
  output logic             fill_half,
  input  logic             rd_en,
  input  logic [HW-1:0]    rd_idx,
  output logic             rd_valid,
  output logic [VEC_W-1:0] rd_data
);
  // stage 0: half check and memory read issue
  logic accept;
  always_comb accept = in_valid && (in_addr[AW-1] == fill_half);

  // stage 1: data back from memory, combine and write
  logic            s1_valid;
  logic [AW-1:0]   s1_addr;
  wmode_e          s1_mode;
  logic            s1_signed;
  logic [IN_W-1:0] s1_psum;

  // forwarding register: the value written at the previous edge
  logic             wb_valid;
  logic [AW-1:0]    wb_addr;
  logic [VEC_W-1:0] wb_data;

  logic [VEC_W-1:0] bank_rd_a, prior_vec, new_vec;
  logic             fwd_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      wb_valid  <= 1'b0;
      in_reject <= 1'b0;
      rd_valid  <= 1'b0;
    end else begin
      s1_valid  <= accept;
      wb_valid  <= s1_valid;
      in_reject <= in_valid && !accept;
      rd_valid  <= rd_en;
    end
  end

  always_ff @(posedge clk) begin
    s1_addr   <= in_addr;
    s1_mode   <= wmode_e'(in_mode);
    s1_signed <= in_signed;
    s1_psum   <= in_psum;
    wb_addr   <= s1_addr;
    wb_data   <= new_vec;
  end

  always_comb begin
    fwd_hit   = wb_valid && (wb_addr == s1_addr);
    prior_vec = fwd_hit ? wb_data : bank_rd_a;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    acc_lane_alu #(.PS_W(PS_W), .ACC_W(ACC_W)) u_alu (
      .psum      (s1_psum[g*PS_W +: PS_W]),
      .is_signed (s1_signed),
      .mode      (s1_mode),
      .prior     (prior_vec[g*ACC_W +: ACC_W]),
      .result    (new_vec[g*ACC_W +: ACC_W])
    );
  end

  acc_bank #(.WIDTH(VEC_W), .DEPTH(DEPTH)) u_bank (
    .clk     (clk),
    .we      (s1_valid),
    .waddr   (s1_addr),
    .wdata   (new_vec),
    .re_a    (accept),
    .raddr_a (in_addr),
    .rdata_a (bank_rd_a),
    .re_b    (rd_en),
    .raddr_b ({~fill_half, rd_idx}),
    .rdata_b (rd_data)
  );

  acc_swap_ctrl u_swap (
    .clk        (clk),
    .rst        (rst),
    .swap_req   (swap_req),
    .drain_done (drain_done),
    .fill_half  (fill_half)
  );

  p_reject_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (in_addr[AW-1] != fill_half)) |=> in_reject);

  p_accept_clean_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (in_addr[AW-1] == fill_half)) |=> !in_reject);

  p_write_in_fill_r6: assert property (@(posedge clk) disable iff (rst)
    s1_valid |-> (s1_addr[AW-1] == $past(fill_half)));

  p_fwd_back_to_back_r5: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && $past(s1_valid) && (s1_addr == $past(s1_addr))) |-> fwd_hit);

  p_read_latency_r8: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  p_read_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);
endmodule

// File: tb/acc_pingpong_store_test.sv
`timescale 1ns/1ps
module acc_pingpong_store_test;
  localparam int LANES = 4, PS_W = 16, ACC_W = 32, DEPTH = 64;
  localparam int AW = 6, HW = 5, HALF = 32;
  localparam int IN_W = LANES * PS_W, VEC_W = LANES * ACC_W;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, in_valid, in_mode, in_signed, in_reject;
  logic swap_req, drain_done, fill_half, rd_en, rd_valid;
  logic [AW-1:0] in_addr;
  logic [IN_W-1:0] in_psum;
  logic [HW-1:0] rd_idx;
  logic [VEC_W-1:0] rd_data;

  acc_pingpong_store #(.LANES(LANES), .PS_W(PS_W), .ACC_W(ACC_W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr), .in_mode(in_mode),
    .in_signed(in_signed), .in_psum(in_psum), .in_reject(in_reject),
    .swap_req(swap_req), .drain_done(drain_done), .fill_half(fill_half),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  int n_run = 0, n_fail = 0;
  logic [ACC_W-1:0] model [DEPTH][LANES];
  logic model_fill = 1'b0, m_req = 1'b0, m_done = 1'b0;
  logic [VEC_W-1:0] exp_q [$];
  string tag_q [$];
  bit pend_rej = 1'b0;
  logic pend_rej_exp = 1'b0;

  task automatic check(string req, logic [VEC_W-1:0] act, logic [VEC_W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (pend_rej) check("R6 reject flag", in_reject, pend_rej_exp);
    pend_rej = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      tick();
      in_valid = 0; rd_en = 0; swap_req = 0; drain_done = 0;
    end
  endtask

  // load/add one vector; the model is updated in program order
  task automatic wr(int addr, bit add, bit sgn, logic [IN_W-1:0] ps);
    tick();
    rd_en = 0; swap_req = 0; drain_done = 0;
    in_valid = 1; in_addr = AW'(addr); in_mode = add; in_signed = sgn; in_psum = ps;
    pend_rej = 1'b1;
    pend_rej_exp = ((addr / HALF) != int'(model_fill));
    if (!pend_rej_exp) begin
      for (int l = 0; l < LANES; l++) begin
        logic [ACC_W-1:0] w;
        w = sgn ? {{(ACC_W-PS_W){ps[l*PS_W+PS_W-1]}}, ps[l*PS_W +: PS_W]}
                : {{(ACC_W-PS_W){1'b0}}, ps[l*PS_W +: PS_W]};
        model[addr][l] = add ? model[addr][l] + w : w;
      end
    end
  endtask

  task automatic rd(int idx, string tag);
    logic [VEC_W-1:0] e;
    int a;
    tick();
    in_valid = 0; swap_req = 0; drain_done = 0;
    rd_en = 1; rd_idx = HW'(idx);
    a = (model_fill ? 0 : HALF) + idx;
    for (int l = 0; l < LANES; l++) e[l*ACC_W +: ACC_W] = model[a][l];
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic pulse(bit req, bit done);
    tick();
    in_valid = 0; rd_en = 0;
    swap_req = req; drain_done = done;
    m_req = m_req | req; m_done = m_done | done;
    if (m_req && m_done) begin
      model_fill = ~model_fill; m_req = 0; m_done = 0;
    end
    idle(1);
    check("R7 fill_half after swap pulse", fill_half, model_fill);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        n_run++; n_fail++;
        $display("FAIL R8 unexpected rd_valid actual=1 expected=0");
      end else begin
        logic [VEC_W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, rd_data, e);
      end
    end
  end

  initial begin
    #(200000 * 5);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1; in_valid = 0; in_addr = '0; in_mode = 0; in_signed = 0; in_psum = '0;
    swap_req = 0; drain_done = 0; rd_en = 0; rd_idx = '0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R9 fill_half reset", fill_half, 0);
    check("R9 in_reject reset", in_reject, 0);
    check("R9 rd_valid reset", rd_valid, 0);

    // fill half 0
    wr(3, 0, 1, 64'h8000_7FFF_0005_FFFF);   // R1 R3 signed load
    wr(4, 0, 0, 64'h8000_7FFF_0005_FFFF);   // R3 unsigned load
    wr(3, 1, 1, 64'h0001_0001_FFFE_0001);   // R2 add, gap 2 from first write
    wr(9, 0, 1, 64'h8000_FFFF_8000_FFFF);
    wr(9, 1, 0, 64'h8000_0001_8000_0001);   // R4 wrap, back to back R5
    wr(7, 0, 0, 64'h0004_0003_0002_0001);
    wr(7, 1, 0, 64'h0010_0020_0030_0040);   // R5 consecutive
    wr(7, 1, 1, 64'hFFFF_FFFE_8000_7FFF);   // R5 consecutive, third
    wr(12, 0, 0, 64'h1111_2222_3333_4444);
    wr(13, 0, 0, 64'hAAAA_BBBB_CCCC_DDDD);
    wr(12, 1, 0, 64'h0001_0002_0003_0004);  // R5 distance two
    wr(40, 0, 0, 64'h1234_1234_1234_1234);  // R6 drain half, rejected
    idle(3);

    pulse(1, 0);                            // R7 request alone
    idle(3);
    check("R7 no swap without done", fill_half, 0);
    pulse(0, 1);                            // R7 done completes swap

    rd(3, "R1/R2/R3/R10 entry 3");
    rd(4, "R3/R10 entry 4");
    rd(9, "R4/R5 entry 9");
    rd(7, "R5 entry 7");
    rd(12, "R5 entry 12");
    rd(13, "R8 entry 13");
    idle(3);

    // fill half 1
    wr(40, 0, 1, 64'hFFFF_0002_8000_0003);
    wr(40, 1, 1, 64'h0001_0002_0003_FFFF);
    wr(3, 0, 0, 64'h5555_5555_5555_5555);   // R6 drain half, rejected
    wr(35, 0, 0, 64'h0F0F_F0F0_00FF_FF00);
    idle(3);
    rd(3, "R6 entry 3 unchanged");
    idle(3);

    pulse(0, 1);                            // R7 done first
    idle(2);
    check("R7 no swap without request", fill_half, 1);
    pulse(1, 0);
    rd(8, "R8/R10 entry 40");
    rd(3, "R8/R10 entry 35");
    idle(2);
    pulse(1, 1);                            // R7 both together
    idle(3);
    check("R8 all reads returned", VEC_W'(exp_q.size()), 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule